// File: doc/BRIEF.md
# Real-Time Clock Calendar Counter

This block keeps wall-clock time and date in a set of byte registers. It counts seconds, minutes, hours, weekday, day of month, month, year and century. A free-running oscillator enable (nominally 32768 Hz) drives a prescaler, and the prescaler produces one time update per second. The counters are stored and advanced in whichever encoding the control register selects: BCD or binary, and 12-hour or 24-hour. The block never converts between encodings. When the mode bits change, software is expected to rewrite the time.

Software reaches every register by number through a byte port that has separate read and write strobes. Read data is registered. The block also provides a time-of-day alarm and a periodic event at a programmable binary fraction of the oscillator. Each of these sets a flag, and the flags are cleared by reading the flag register. One interrupt output combines the flags that are enabled. Writing any time register restarts the prescaler, so the first update after setting the clock comes a full second later.

Top module: `rtc_calendar`

## Requirements
- R1: Registers sit at fixed numbers, and a written value reads back unchanged while no update occurs:
  - seconds at 0x00, minutes at 0x02, hours at 0x04, weekday at 0x06, day of month at 0x07, month at 0x08, year at 0x09 and century at 0x32;
  - alarm seconds at 0x01, alarm minutes at 0x03 and alarm hours at 0x05;
  - rate control at 0x0A and mode control at 0x0B.
- R2: An update happens after every 2^PRESCALE_W oscillator enables. A write to any time register restarts the prescaler, so the next update lands exactly 2^PRESCALE_W enabled cycles after that write.
- R3: When mode bit 2 is clear, the counters use BCD with one decimal digit per nibble (0x09 steps to 0x10, and 0x59 wraps to 0x00 with a carry).
- R4: When mode bit 2 is set, the counters are plain binary (0x3B wraps to 0x00 with a carry).
- R5: When mode bit 1 is set, the hour runs from 0 to 23, and the step from 23 to 0 advances the date.
- R6: When mode bit 1 is clear, the hour runs 12, 1, ..., 11 and bit 7 flags PM:
  - 11 AM steps to 12 PM;
  - 11 PM steps to 12 AM (midnight) and advances the date;
  - 12 steps to 1 with the PM flag unchanged.
- R7: The weekday runs from 1 (Sunday) to 7 (Saturday) and wraps from 7 to 1 on each date advance.
- R8: The day of month wraps to 1 after the last day of the month. April, June, September and November have 30 days, and February has 29 days when the year value is divisible by 4 and 28 otherwise.
- R9: The month wraps from 12 to 1 and advances the year. The year wraps from 99 to 0 and advances the century.
- R10: An update whose new seconds, minutes and hours all equal the alarm registers sets the alarm flag, which is bit 5 of the flag register at 0x0C.
- R11: The periodic flag (bit 6 of 0x0C) sets once every 2^(rate-1) oscillator enables, where rate is bits 3:0 of 0x0A. Rates 1 and 2 behave as rate 3, and rate 0 disables the flag.
- R12: Reading 0x0C clears both flags, but a flag event in the same cycle wins. Bit 7 of 0x0C and irq_o both equal (alarm flag AND mode bit 5) OR (periodic flag AND mode bit 6).
- R13: Reset state: time 00:00:00 on weekday 1, day 1, month 1, year 0x00, century 0x20; mode 0x02 (24-hour BCD); rate 0; no flags; irq_o low.
- R14: reg_rdata_o takes the addressed value on the cycle after reg_rd_i is high, and holds it otherwise. Unused numbers read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | Oscillator enable, one pulse per oscillator period |
| reg_addr_i | input | 7 | Register number for the read or write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined enabled interrupt flags |

## Verification
The bench holds the oscillator enable high, so one second lasts 2^PRESCALE_W clock cycles after the last time-register write. It reads the time either just before or well inside the following second, and for R2 it samples exactly at cycles 31 and 33. Read data is due one cycle after the strobe, and a scoreboard monitor compares it at the falling edge after the capturing edge. Flags are due one cycle after their event, so the periodic checks read 0x0C on each of 64 consecutive edges and count the set bits, which gives a result that does not depend on the divider phase.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [6:0] REG_SEC   = 7'h00;
  localparam logic [6:0] REG_ASEC  = 7'h01;
  localparam logic [6:0] REG_MIN   = 7'h02;
  localparam logic [6:0] REG_AMIN  = 7'h03;
  localparam logic [6:0] REG_HOUR  = 7'h04;
  localparam logic [6:0] REG_AHOUR = 7'h05;
  localparam logic [6:0] REG_WDAY  = 7'h06;
  localparam logic [6:0] REG_MDAY  = 7'h07;
  localparam logic [6:0] REG_MON   = 7'h08;
  localparam logic [6:0] REG_YEAR  = 7'h09;
  localparam logic [6:0] REG_RATE  = 7'h0A;
  localparam logic [6:0] REG_MODE  = 7'h0B;
  localparam logic [6:0] REG_FLAG  = 7'h0C;
  localparam logic [6:0] REG_CENT  = 7'h32;

  localparam int MODE_24H = 1;
  localparam int MODE_BIN = 2;
  localparam int MODE_AIE = 5;
  localparam int MODE_PIE = 6;

  localparam rtc_time_t RTC_RST = '{cent: 8'h20, year: 8'h00, mon: 8'h01, mday: 8'h01,
                                    wday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  // encode a small number in the active format
  function automatic logic [7:0] enc(input int unsigned n, input logic bin);
    enc = bin ? 8'(n) : {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] dec(input logic [7:0] v, input logic bin);
    dec = bin ? v : ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] step(input logic [7:0] v, input logic bin);
    if (bin) step = v + 8'd1;
    else if (v[3:0] >= 4'd9) step = {v[7:4] + 4'd1, 4'd0};
    else step = v + 8'd1;
  endfunction

  function automatic int unsigned days_in(input logic [7:0] m, input logic leap);
    case (m)
      8'd2:                    days_in = leap ? 29 : 28;
      8'd4, 8'd6, 8'd9, 8'd11: days_in = 30;
      default:                 days_in = 31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE_W = 15,
  parameter int PDIV_W     = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [3:0] rate_i,
  output logic       sec_tick_o,
  output logic       per_evt_o
);
  logic [PRESCALE_W-1:0] cnt_q;
  logic [PDIV_W-1:0]     pdiv_q;
  logic [3:0]            rate_eff;
  logic [3:0]            shift;
  logic [PDIV_W-1:0]     mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pdiv_q <= '0;
    end else begin
      if (restart_i)   cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (tick_i)      pdiv_q <= pdiv_q + 1'b1;
    end
  end

  assign sec_tick_o = tick_i && (&cnt_q);

  // rates 1 and 2 clamp to the fastest legal period of 4 ticks
  always_comb begin
    rate_eff = (rate_i < 4'd3) ? 4'd3 : rate_i;
    shift    = rate_eff - 4'd1;
    mask     = ~({PDIV_W{1'b1}} << shift);
  end

  assign per_evt_o = tick_i && (rate_i != 4'd0) && ((pdiv_q & mask) == mask);

  assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

  assert_per_spacing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_evt_o |=> !per_evt_o);

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_tick_i,
  input  logic       wr_en_i,
  input  logic [6:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       h24_i,
  input  logic       bin_i,
  output logic       wr_hit_o,
  output logic       upd_o,
  output rtc_time_t  time_o,
  output rtc_time_t  time_nxt_o
);
  rtc_time_t  time_q, nxt;
  logic       day_c;
  logic [7:0] hf, hstep, e12, dim, yb;
  logic       leap;

  assign wr_hit_o = wr_en_i && (wr_addr_i inside {REG_SEC, REG_MIN, REG_HOUR, REG_WDAY,
                                                 REG_MDAY, REG_MON, REG_YEAR, REG_CENT});
  assign upd_o    = sec_tick_i && !wr_hit_o;

  always_comb begin
    nxt   = time_q;
    day_c = 1'b0;
    hf    = {1'b0, time_q.hour[6:0]};
    hstep = step(hf, bin_i);
    e12   = enc(12, bin_i);
    yb    = dec(time_q.year, bin_i);
    leap  = (yb[1:0] == 2'b00);
    dim   = enc(days_in(dec(time_q.mon, bin_i), leap), bin_i);
    if (time_q.sec == enc(59, bin_i)) begin
      nxt.sec = 8'h00;
      if (time_q.min == enc(59, bin_i)) begin
        nxt.min = 8'h00;
        if (h24_i) begin
          if (time_q.hour == enc(23, bin_i)) begin
            nxt.hour = 8'h00;
            day_c    = 1'b1;
          end else begin
            nxt.hour = step(time_q.hour, bin_i);
          end
        end else if (hf == e12) begin
          nxt.hour = {time_q.hour[7], 7'd1};
        end else if (hf == enc(11, bin_i)) begin
          nxt.hour = {~time_q.hour[7], e12[6:0]};
          day_c    = time_q.hour[7];
        end else begin
          nxt.hour = {time_q.hour[7], hstep[6:0]};
        end
      end else begin
        nxt.min = step(time_q.min, bin_i);
      end
    end else begin
      nxt.sec = step(time_q.sec, bin_i);
    end
    if (day_c) begin
      nxt.wday = (time_q.wday == 8'd7) ? 8'd1 : time_q.wday + 8'd1;
      if (time_q.mday == dim) begin
        nxt.mday = 8'h01;
        if (time_q.mon == enc(12, bin_i)) begin
          nxt.mon = 8'h01;
          if (time_q.year == enc(99, bin_i)) begin
            nxt.year = 8'h00;
            nxt.cent = (time_q.cent == enc(99, bin_i)) ? 8'h00 : step(time_q.cent, bin_i);
          end else begin
            nxt.year = step(time_q.year, bin_i);
          end
        end else begin
          nxt.mon = step(time_q.mon, bin_i);
        end
      end else begin
        nxt.mday = step(time_q.mday, bin_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= RTC_RST;
    end else if (wr_hit_o) begin
      case (wr_addr_i)
        REG_SEC:  time_q.sec  <= wr_data_i;
        REG_MIN:  time_q.min  <= wr_data_i;
        REG_HOUR: time_q.hour <= wr_data_i;
        REG_WDAY: time_q.wday <= wr_data_i;
        REG_MDAY: time_q.mday <= wr_data_i;
        REG_MON:  time_q.mon  <= wr_data_i;
        REG_YEAR: time_q.year <= wr_data_i;
        REG_CENT: time_q.cent <= wr_data_i;
        default: ;
      endcase
    end else if (sec_tick_i) begin
      time_q <= nxt;
    end
  end

  assign time_o     = time_q;
  assign time_nxt_o = nxt;

  assert_sec_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !$stable(time_q.sec));

  assert_wday_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && day_c && time_q.wday == 8'd7) |=> (time_q.wday == 8'd1));

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alarm_evt_i,
  input  logic       per_evt_i,
  input  logic       clr_i,
  input  logic       aie_i,
  input  logic       pie_i,
  output logic [7:0] flag_byte_o,
  output logic       irq_o
);
  logic af_q, pf_q;

  // a new event wins over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q <= 1'b0;
      pf_q <= 1'b0;
    end else begin
      if (alarm_evt_i) af_q <= 1'b1;
      else if (clr_i)  af_q <= 1'b0;
      if (per_evt_i)   pf_q <= 1'b1;
      else if (clr_i)  pf_q <= 1'b0;
    end
  end

  assign irq_o       = (af_q && aie_i) || (pf_q && pie_i);
  assign flag_byte_o = {irq_o, pf_q, af_q, 5'b0};

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !alarm_evt_i && !per_evt_i) |=> (!af_q && !pf_q));

  assert_irq_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(alarm_evt_i || per_evt_i) || $rose(aie_i) || $rose(pie_i)));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRESCALE_W = 15,
  parameter int PDIV_W     = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic [6:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       reg_rd_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  rtc_time_t  tm, tm_nxt;
  logic [7:0] asec_q, amin_q, ahour_q, rate_q, mode_q, flag_byte, rd_mux, rdata_q;
  logic       sec_tick, per_evt, wr_hit, upd, alarm_evt, flag_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asec_q  <= 8'h00;
      amin_q  <= 8'h00;
      ahour_q <= 8'h00;
      rate_q  <= 8'h00;
      mode_q  <= 8'h02;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        REG_ASEC:  asec_q  <= reg_wdata_i;
        REG_AMIN:  amin_q  <= reg_wdata_i;
        REG_AHOUR: ahour_q <= reg_wdata_i;
        REG_RATE:  rate_q  <= reg_wdata_i;
        REG_MODE:  mode_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  rtc_prescaler #(.PRESCALE_W(PRESCALE_W), .PDIV_W(PDIV_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (osc_tick_i),
    .restart_i  (wr_hit),
    .rate_i     (rate_q[3:0]),
    .sec_tick_o (sec_tick),
    .per_evt_o  (per_evt)
  );

  rtc_time_regs u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick),
    .wr_en_i    (reg_wr_i),
    .wr_addr_i  (reg_addr_i),
    .wr_data_i  (reg_wdata_i),
    .h24_i      (mode_q[MODE_24H]),
    .bin_i      (mode_q[MODE_BIN]),
    .wr_hit_o   (wr_hit),
    .upd_o      (upd),
    .time_o     (tm),
    .time_nxt_o (tm_nxt)
  );

  assign alarm_evt = upd && (tm_nxt.sec == asec_q) && (tm_nxt.min == amin_q)
                         && (tm_nxt.hour == ahour_q);
  assign flag_clr  = reg_rd_i && (reg_addr_i == REG_FLAG);

  rtc_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alarm_evt_i (alarm_evt),
    .per_evt_i   (per_evt),
    .clr_i       (flag_clr),
    .aie_i       (mode_q[MODE_AIE]),
    .pie_i       (mode_q[MODE_PIE]),
    .flag_byte_o (flag_byte),
    .irq_o       (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      REG_SEC:   rd_mux = tm.sec;
      REG_ASEC:  rd_mux = asec_q;
      REG_MIN:   rd_mux = tm.min;
      REG_AMIN:  rd_mux = amin_q;
      REG_HOUR:  rd_mux = tm.hour;
      REG_AHOUR: rd_mux = ahour_q;
      REG_WDAY:  rd_mux = tm.wday;
      REG_MDAY:  rd_mux = tm.mday;
      REG_MON:   rd_mux = tm.mon;
      REG_YEAR:  rd_mux = tm.year;
      REG_RATE:  rd_mux = rate_q;
      REG_MODE:  rd_mux = mode_q;
      REG_FLAG:  rd_mux = flag_byte;
      REG_CENT:  rd_mux = tm.cent;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= 8'h00;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;

  assert_rdata_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));

  assert_alarm_needs_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt |-> (sec_tick && osc_tick_i));

endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [6:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic exp_rd = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  rtc_calendar #(.PRESCALE_W(5), .PDIV_W(14)) dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; exp_rd = 1'b1;
    sbq.push_back('{e, tag});
    @(negedge clk);
    reg_rd = 1'b0; exp_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, d, w, h, mi, s);
    wr(7'h00, s); wr(7'h02, mi); wr(7'h04, h); wr(7'h06, w);
    wr(7'h07, d); wr(7'h08, mo); wr(7'h09, y); wr(7'h32, c);
  endtask

  task automatic expect_time(input logic [7:0] c, y, mo, d, w, h, mi, s, input string tag);
    rd(7'h00, s, {tag, " sec"});   rd(7'h02, mi, {tag, " min"});
    rd(7'h04, h, {tag, " hour"});  rd(7'h06, w, {tag, " wday"});
    rd(7'h07, d, {tag, " mday"});  rd(7'h08, mo, {tag, " mon"});
    rd(7'h09, y, {tag, " year"});  rd(7'h32, c, {tag, " cent"});
  endtask

  // reads the flag register on 65 consecutive edges and counts periodic flags in the last 64
  task automatic count_pf(input logic [3:0] rate, input int exp, input string tag);
    int n = 0;
    logic sawirq = 1'b0;
    wr(7'h0A, {4'h0, rate});
    reg_addr = 7'h0C; reg_rd = 1'b1;
    for (int i = 0; i <= 64; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (reg_rdata[6]) n++;
        if (reg_rdata[7]) sawirq = 1'b1;
      end
    end
    reg_rd = 1'b0;
    check8({tag, " periodic count"}, 8'(n), 8'(exp));
    check8("R12 irq bit stays low with periodic enable off", {7'd0, sawirq}, 8'd0);
  endtask

  // scoreboard monitor
  initial begin
    logic seen;
    exp_t e;
    forever begin
      @(posedge clk);
      seen = exp_rd;
      @(negedge clk);
      if (seen) begin
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard empty actual=%h expected=none", reg_rdata);
        end else begin
          e = sbq.pop_front();
          check8(e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    // R13 reset state
    check8("R13 irq low after reset", {7'd0, irq}, 8'd0);
    expect_time(8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R13 reset");
    rd(7'h0B, 8'h02, "R13 mode reset");
    rd(7'h0A, 8'h00, "R13 rate reset");
    rd(7'h0C, 8'h00, "R13 flags reset");
    rd(7'h40, 8'h00, "R14 unused number reads zero");

    // R1 readback, 24-hour BCD
    wr(7'h01, 8'h30); wr(7'h03, 8'h15); wr(7'h05, 8'h07); wr(7'h0A, 8'h20);
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h13, 8'h45, 8'h09);
    expect_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h13, 8'h45, 8'h09, "R1 readback");
    rd(7'h01, 8'h30, "R1 alarm sec"); rd(7'h03, 8'h15, "R1 alarm min");
    rd(7'h05, 8'h07, "R1 alarm hour"); rd(7'h0A, 8'h20, "R1 rate reg");
    wait_cyc(22);
    rd(7'h00, 8'h10, "R3 BCD 09 to 10");

    // R2 exact update cycle after a time write
    wr(7'h00, 8'h00);
    wait_cyc(29);
    rd(7'h00, 8'h00, "R2 no update before 32 ticks");
    rd(7'h00, 8'h01, "R2 update at 32 ticks");

    // R4 R5 R7 R8 binary 24-hour, leap February
    wr(7'h0B, 8'h06);
    set_time(8'h14, 8'h04, 8'h02, 8'h1C, 8'h07, 8'h17, 8'h3B, 8'h3B);
    wait_cyc(38);
    expect_time(8'h14, 8'h04, 8'h02, 8'h1D, 8'h01, 8'h00, 8'h00, 8'h00, "R4 R5 R7 R8 leap");

    // R8 binary 30-day month
    set_time(8'h14, 8'h05, 8'h04, 8'h1E, 8'h02, 8'h17, 8'h3B, 8'h3B);
    wait_cyc(38);
    expect_time(8'h14, 8'h05, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, "R8 April end");

    // R3 R8 BCD non-leap February
    wr(7'h0B, 8'h02);
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h04, 8'h23, 8'h59, 8'h59);
    wait_cyc(38);
    expect_time(8'h20, 8'h23, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00, "R3 R8 non-leap");

    // R9 year and century rollover
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    wait_cyc(38);
    expect_time(8'h20, 8'h00, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00, "R9 century");

    // R6 12-hour BCD: 11 PM to 12 AM advances the date
    wr(7'h0B, 8'h00);
    set_time(8'h20, 8'h24, 8'h03, 8'h10, 8'h03, 8'h91, 8'h59, 8'h59);
    wait_cyc(38);
    expect_time(8'h20, 8'h24, 8'h03, 8'h11, 8'h04, 8'h12, 8'h00, 8'h00, "R6 PM to midnight");

    // R6 12-hour binary: 11 AM to 12 PM, no date change
    wr(7'h0B, 8'h04);
    set_time(8'h14, 8'h18, 8'h03, 8'h0A, 8'h03, 8'h0B, 8'h3B, 8'h3B);
    wait_cyc(38);
    expect_time(8'h14, 8'h18, 8'h03, 8'h0A, 8'h03, 8'h8C, 8'h00, 8'h00, "R6 AM to noon");

    // R6 12 PM to 1 PM keeps PM flag
    set_time(8'h14, 8'h18, 8'h03, 8'h0A, 8'h03, 8'h8C, 8'h3B, 8'h3B);
    wait_cyc(38);
    rd(7'h04, 8'h81, "R6 12 to 1 keeps PM");

    // R10 R12 alarm, 24-hour BCD with alarm enable
    wr(7'h0B, 8'h22);
    wr(7'h01, 8'h00); wr(7'h03, 8'h00); wr(7'h05, 8'h12);
    rd(7'h0C, 8'h00, "R12 flags clear before alarm");
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h11, 8'h59, 8'h59);
    check8("R10 irq low before match", {7'd0, irq}, 8'd0);
    wait_cyc(38);
    check8("R10 irq high after match", {7'd0, irq}, 8'd1);
    rd(7'h0C, 8'hA0, "R10 R12 alarm flag and irq bit");
    check8("R12 irq low after flag read", {7'd0, irq}, 8'd0);
    rd(7'h0C, 8'h00, "R12 flags cleared by read");
    rd(7'h04, 8'h12, "R10 hour at alarm");

    // R11 periodic rates with periodic enable off
    wr(7'h0B, 8'h02);
    count_pf(4'd3, 16, "R11 rate 3");
    count_pf(4'd1, 16, "R11 rate 1 clamped");
    count_pf(4'd5, 4,  "R11 rate 5");
    count_pf(4'd0, 0,  "R11 rate 0 off");

    // R12 periodic enable drives irq
    wr(7'h0A, 8'h03);
    wr(7'h0B, 8'h42);
    wait_cyc(8);
    check8("R12 irq from periodic flag", {7'd0, irq}, 8'd1);
    wr(7'h0A, 8'h00);
    rd(7'h0C, 8'hC0, "R11 R12 periodic flag with irq bit");
    rd(7'h0C, 8'h00, "R11 no flag at rate 0");
    check8("R12 irq low at rate 0", {7'd0, irq}, 8'd0);

    wait_cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule